// File: doc/BRIEF.md
# LCD Pixel Output Conditioning Stage

This block sits between the pixel fetch path and the panel data pins. It holds one 32-bit memory word at a time and emits one pixel from it on each cycle in which pixel-valid is asserted, starting from the most significant bits. The pixel width follows a 3-bit depth code. When a word is used up, the block asks for the next one.

Each pixel either goes to the panel as is, zero-extended into the low bits of the 24-bit bus, or picks an entry from a 256-entry colour table. The table is only consulted at 1 to 8 bits per pixel. After that, inverse video and blanking are applied. Both controls are sampled at a frame-start pulse, so the picture never changes part way through a scan.

A frame counter, enabled by a control bit, counts frame-start pulses. Each time it wraps, it signals a modulation pattern generator to restart its pattern. Control fields and table entries are reached through a simple write port with a combinational read port.

Top module: `lcd_pixel_conditioner`

## Requirements
- R1: Depth code 0..6 selects 1, 2, 4, 8, 12, 16 or 24 bits per pixel. Pixels are taken from the word most significant first. At 1/2/4/8 bpp the word holds 32/16/8/4 pixels. At 12 and 16 bpp it holds 2 pixels, and at 24 bpp it holds 1 pixel, each aligned to the top of the word with the unused low bits ignored.
- R2: Depth code 7 behaves exactly as 1 bpp.
- R3: `word_req` is high whenever no word is held. A word offered with `word_valid` while `word_req` is high is taken. After its last pixel is emitted, `word_req` rises again. A pixel-valid pulse while no word is held produces no output.
- R4: `panel_valid` rises exactly one clock after an accepted pixel-valid cycle and stays low otherwise.
- R5: The control register (address 0) uses these bits: [2:0] depth, [3] table bypass, [4] invert, [5] blank, [6] frame repeat. After reset it reads 0x08 (1 bpp, bypassed, invert, blank and repeat off).
- R6: With bypass on, the raw pixel value appears zero-extended in the low bits of `panel_data`.
- R7: With bypass off at 1 to 8 bpp, `panel_data` is the table entry indexed by the pixel value.
- R8: At 12, 16 and 24 bpp the table is never used, whatever the bypass bit says.
- R9: With invert active, all 24 output bits are complemented.
- R10: With blank active, every output bit equals the active invert setting (all zeros or all ones).
- R11: Invert and blank written to the control register take effect only for pixels emitted after the next `frame_start` pulse.
- R12: With repeat on, the counter advances on each `frame_start`. The `frame_start` that finds it at `FRAME_WRAP` sets it back to 0 and produces a one-cycle `frame_restart` pulse on the next clock.
- R13: With repeat off, the counter is held at 0 and `frame_restart` never pulses. Re-enabling repeat starts the count from 0.
- R14: Table entry n is written and read back at address 0x100+n, in bits [23:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register address: 0 for control, 0x100+n for table entry n |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| word_valid | input | 1 | A memory word is offered |
| word_data | input | 32 | Offered memory word |
| word_req | output | 1 | Block holds no word and will take one |
| pix_valid | input | 1 | Emit the next pixel |
| frame_start | input | 1 | Frame start pulse |
| panel_data | output | 24 | Conditioned panel data |
| panel_valid | output | 1 | `panel_data` carries a new pixel |
| frame_restart | output | 1 | Modulation pattern restart pulse |

## Verification
One fixed word with an irregular bit pattern is unpacked at every depth code, including the reserved one, with the table both bypassed and selected. This separates slot position, pixel width, bypass forcing and table indexing, because each of these picks a different value from the same word. Invert and blank are walked through all their combinations inside a single word, with frame-start pulses placed between pixels, so a control applied early or late gives a wrong value. The frame counter is run with a small wrap value through enable, disable and re-enable, which shows both where the restart pulse falls and that disabling clears the count.

// File: rtl/lcdpx_pkg.sv
package lcdpx_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    DEPTH_1   = 3'd0,
    DEPTH_2   = 3'd1,
    DEPTH_4   = 3'd2,
    DEPTH_8   = 3'd3,
    DEPTH_12  = 3'd4,
    DEPTH_16  = 3'd5,
    DEPTH_24  = 3'd6,
    DEPTH_RSV = 3'd7
  } depth_e;

  typedef struct packed {
    logic   repeat_en;
    logic   blank;
    logic   invert;
    logic   lut_bypass;
    depth_e depth;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // bits per pixel for a depth code; the reserved code folds onto 1 bpp
  function automatic logic [5:0] depth_bits(depth_e d);
    case (d)
      DEPTH_2:  return 6'd2;
      DEPTH_4:  return 6'd4;
      DEPTH_8:  return 6'd8;
      DEPTH_12: return 6'd12;
      DEPTH_16: return 6'd16;
      DEPTH_24: return 6'd24;
      default:  return 6'd1;
    endcase
  endfunction

  // pixels held in one memory word
  function automatic logic [5:0] depth_ppw(depth_e d);
    case (d)
      DEPTH_2:  return 6'd16;
      DEPTH_4:  return 6'd8;
      DEPTH_8:  return 6'd4;
      DEPTH_12: return 6'd2;
      DEPTH_16: return 6'd2;
      DEPTH_24: return 6'd1;
      default:  return 6'd32;
    endcase
  endfunction

  function automatic logic depth_is_deep(depth_e d);
    return (d == DEPTH_12) || (d == DEPTH_16) || (d == DEPTH_24);
  endfunction

endpackage

// File: rtl/lcdpx_regs.sv
module lcdpx_regs
  import lcdpx_pkg::*;
#(
  parameter int PIX_W  = 24,
  parameter int LUT_AW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [LUT_AW:0]     addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata,
  output ctrl_t               ctrl,
  input  logic [LUT_AW-1:0]   lut_idx,
  output logic [PIX_W-1:0]    lut_data
);

  localparam int LUT_N = 1 << LUT_AW;
  localparam ctrl_t CTRL_RST = '{repeat_en: 1'b0, blank: 1'b0, invert: 1'b0,
                                 lut_bypass: 1'b1, depth: DEPTH_1};

  logic              sel_lut;
  logic              ctrl_we;
  ctrl_t             ctrl_q, ctrl_d;
  logic [PIX_W-1:0]  lut_q [LUT_N];

  assign sel_lut = addr[LUT_AW];
  assign ctrl_we = wr_en && !sel_lut && (addr[LUT_AW-1:0] == '0);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= ctrl_d;
  end

  // one enabled register per table entry
  for (genvar g = 0; g < LUT_N; g++) begin : g_lut
    logic entry_we;
    assign entry_we = wr_en && sel_lut && (addr[LUT_AW-1:0] == LUT_AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lut_q[g] <= '0;
      else if (entry_we) lut_q[g] <= wdata[PIX_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_lut)                          rdata[PIX_W-1:0]  = lut_q[addr[LUT_AW-1:0]];
    else if (addr[LUT_AW-1:0] == '0)      rdata[CTRL_W-1:0] = ctrl_q;
  end

  assign ctrl     = ctrl_q;
  assign lut_data = lut_q[lut_idx];

  assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> (ctrl_q == $past(ctrl_q)));

endmodule

// File: rtl/lcdpx_unpack.sv
module lcdpx_unpack
  import lcdpx_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  depth_e             depth,
  input  logic               word_valid,
  input  logic [WORD_W-1:0]  word_data,
  output logic               word_req,
  input  logic               pix_valid,
  output logic               pix_fire,
  output logic [PIX_W-1:0]   pix_data
);

  localparam int IDX_W = 6;

  logic [WORD_W-1:0] word_q, word_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              have_q, have_d;
  logic [5:0]        bpp, ppw;
  logic              pix_last;
  logic [6:0]        end_bit, shamt;
  logic [WORD_W-1:0] shifted;
  logic [WORD_W:0]   mask;

  assign bpp      = depth_bits(depth);
  assign ppw      = depth_ppw(depth);
  assign word_req = !have_q;
  assign pix_fire = pix_valid && have_q;
  assign pix_last = (idx_q >= (ppw - 6'd1));

  // slot n ends (n+1)*bpp bits below the top of the word
  always_comb begin
    end_bit  = {1'b0, bpp} * (7'(idx_q) + 7'd1);
    shamt    = 7'd32 - end_bit;
    shifted  = word_q >> shamt;
    mask     = ({{WORD_W{1'b0}}, 1'b1} << bpp) - 1'b1;
    pix_data = shifted[PIX_W-1:0] & mask[PIX_W-1:0];
  end

  always_comb begin
    word_d = word_q;
    idx_d  = idx_q;
    have_d = have_q;
    if (pix_fire) begin
      if (pix_last) begin
        have_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d  = idx_q + 1'b1;
      end
    end
    if (word_valid && !have_q) begin
      word_d = word_data;
      idx_d  = '0;
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
      have_q <= 1'b0;
    end else begin
      word_q <= word_d;
      idx_q  <= idx_d;
      have_q <= have_d;
    end
  end

  assert_req_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_fire && pix_last) |=> word_req);

  assert_no_fire_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_req |-> !pix_fire);

endmodule

// File: rtl/lcdpx_frame_cnt.sv
module lcdpx_frame_cnt #(
  parameter int          FCNT_W     = 19,
  parameter int unsigned FRAME_WRAP = 32'h40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic frame_start,
  output logic restart
);

  localparam logic [FCNT_W-1:0] WRAP_V = FCNT_W'(FRAME_WRAP);

  logic [FCNT_W-1:0] cnt_q, cnt_d;
  logic              restart_q, restart_d;
  logic              at_wrap;

  assign at_wrap = (cnt_q == WRAP_V);

  always_comb begin
    cnt_d     = cnt_q;
    restart_d = 1'b0;
    if (!enable) begin
      cnt_d = '0;
    end else if (frame_start) begin
      cnt_d     = at_wrap ? '0 : cnt_q + 1'b1;
      restart_d = at_wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      restart_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      restart_q <= restart_d;
    end
  end

  assign restart = restart_q;

  assert_cnt_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= WRAP_V);

  assert_restart_at_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |-> (cnt_q == '0));

  assert_cleared_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0));

  assert_no_restart_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !restart_q);

endmodule

// File: rtl/lcdpx_outstage.sv
module lcdpx_outstage #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [PIX_W-1:0] raw,
  input  logic [PIX_W-1:0] lut_val,
  input  logic             use_lut,
  input  logic             frame_start,
  input  logic             invert_req,
  input  logic             blank_req,
  output logic [PIX_W-1:0] panel_data,
  output logic             panel_valid
);

  logic             act_inv_q, act_inv_d;
  logic             act_blank_q, act_blank_d;
  logic [PIX_W-1:0] data_q, data_d;
  logic             valid_q;
  logic [PIX_W-1:0] sel, cond;

  always_comb begin
    act_inv_d   = act_inv_q;
    act_blank_d = act_blank_q;
    if (frame_start) begin
      act_inv_d   = invert_req;
      act_blank_d = blank_req;
    end
  end

  always_comb begin
    sel    = use_lut ? lut_val : raw;
    cond   = act_blank_q ? {PIX_W{act_inv_q}} : (sel ^ {PIX_W{act_inv_q}});
    data_d = fire ? cond : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_inv_q   <= 1'b0;
      act_blank_q <= 1'b0;
      data_q      <= '0;
      valid_q     <= 1'b0;
    end else begin
      act_inv_q   <= act_inv_d;
      act_blank_q <= act_blank_d;
      data_q      <= data_d;
      valid_q     <= fire;
    end
  end

  assign panel_data  = data_q;
  assign panel_valid = valid_q;

  assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> panel_valid);

  assert_valid_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !panel_valid);

  assert_blank_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && act_blank_q) |=> (panel_data == {PIX_W{$past(act_inv_q)}}));

  assert_frame_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(act_inv_q) && $stable(act_blank_q)));

endmodule

// File: rtl/lcd_pixel_conditioner.sv
module lcd_pixel_conditioner
  import lcdpx_pkg::*;
#(
  parameter int          PIX_W      = 24,
  parameter int          LUT_AW     = 8,
  parameter int          FCNT_W     = 19,
  parameter int unsigned FRAME_WRAP = 32'h40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [LUT_AW:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              word_valid,
  input  logic [31:0]       word_data,
  output logic              word_req,
  input  logic              pix_valid,
  input  logic              frame_start,
  output logic [PIX_W-1:0]  panel_data,
  output logic              panel_valid,
  output logic              frame_restart
);

  ctrl_t             ctrl;
  logic              fire;
  logic [PIX_W-1:0]  raw_pix;
  logic [PIX_W-1:0]  lut_val;
  logic              use_lut;

  lcdpx_regs #(.PIX_W(PIX_W), .LUT_AW(LUT_AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .ctrl     (ctrl),
    .lut_idx  (raw_pix[LUT_AW-1:0]),
    .lut_data (lut_val)
  );

  lcdpx_unpack #(.PIX_W(PIX_W)) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n),
    .depth      (ctrl.depth),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_req   (word_req),
    .pix_valid  (pix_valid),
    .pix_fire   (fire),
    .pix_data   (raw_pix)
  );

  // the table is only legal at the shallow depths
  assign use_lut = !ctrl.lut_bypass && !depth_is_deep(ctrl.depth);

  lcdpx_outstage #(.PIX_W(PIX_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .raw         (raw_pix),
    .lut_val     (lut_val),
    .use_lut     (use_lut),
    .frame_start (frame_start),
    .invert_req  (ctrl.invert),
    .blank_req   (ctrl.blank),
    .panel_data  (panel_data),
    .panel_valid (panel_valid)
  );

  lcdpx_frame_cnt #(.FCNT_W(FCNT_W), .FRAME_WRAP(FRAME_WRAP)) u_fcnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (ctrl.repeat_en),
    .frame_start (frame_start),
    .restart     (frame_restart)
  );

  assert_deep_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    depth_is_deep(ctrl.depth) |-> !use_lut);

endmodule

// File: tb/lcd_pixel_conditioner_bench.sv
module lcd_pixel_conditioner_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WRAP       = 3;
  localparam logic [31:0] W = 32'hC3A5_9E17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_req;
  logic        pix_valid = 1'b0;
  logic        frame_start = 1'b0;
  logic [23:0] panel_data;
  logic        panel_valid;
  logic        frame_restart;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_pixel_conditioner #(.FRAME_WRAP(WRAP)) u_lcd_pixel_conditioner (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .word_valid(word_valid),
    .word_data(word_data), .word_req(word_req), .pix_valid(pix_valid),
    .frame_start(frame_start), .panel_data(panel_data),
    .panel_valid(panel_valid), .frame_restart(frame_restart)
  );

  // ctrl bits: [2:0] depth, [3] bypass, [4] invert, [5] blank, [6] repeat
  typedef struct packed {
    logic [7:0]  ctrl;
    logic [5:0]  slot;
    logic [23:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'h08, 6'd0,  24'h000001},  // R1 R6 1 bpp first slot
    '{8'h08, 6'd2,  24'h000000},  // R1 1 bpp slot 2
    '{8'h09, 6'd3,  24'h000003},  // R1 2 bpp
    '{8'h0A, 6'd2,  24'h00000A},  // R1 4 bpp
    '{8'h0B, 6'd1,  24'h0000A5},  // R1 8 bpp
    '{8'h03, 6'd3,  24'hA517E8},  // R7 8 bpp via table
    '{8'h02, 6'd7,  24'hA507F8},  // R7 4 bpp via table, last slot
    '{8'h00, 6'd31, 24'hA501FE},  // R7 1 bpp via table, last slot
    '{8'h01, 6'd15, 24'hA503FC},  // R7 2 bpp via table
    '{8'h04, 6'd0,  24'h000C3A},  // R8 12 bpp forced bypass
    '{8'h04, 6'd1,  24'h00059E},  // R8 R1 12 bpp second slot
    '{8'h05, 6'd1,  24'h009E17},  // R8 16 bpp
    '{8'h06, 6'd0,  24'hC3A59E},  // R8 24 bpp single slot
    '{8'h0F, 6'd6,  24'h000001}   // R2 reserved code as 1 bpp
  };

  function automatic logic [23:0] lut_of(int i);
    logic [7:0] b;
    b = i[7:0];
    return {8'hA5, b, ~b};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic load(logic [31:0] w);
    @(negedge clk);
    word_valid = 1'b1; word_data = w;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic emit(output logic v, output logic [23:0] d);
    @(negedge clk);
    pix_valid = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
    v = panel_valid;
    d = panel_data;
  endtask

  task automatic fstart(output logic r);
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    r = frame_restart;
  endtask

  task automatic drain();
    logic v;
    logic [23:0] d;
    for (int g = 0; g < 40 && !word_req; g++) emit(v, d);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic        v;
    logic [23:0] d;
    logic        r;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state (R5, R3, R4, R12)
    rd(9'h000, rv);
    check("R5 ctrl reset", rv, 32'h08);
    check("R3 word_req reset", {31'd0, word_req}, 32'd1);
    check("R4 panel_valid reset", {31'd0, panel_valid}, 32'd0);
    check("R12 restart reset", {31'd0, frame_restart}, 32'd0);

    // R3: pixel request with no word gives no output
    emit(v, d);
    check("R3 no word no output", {31'd0, v}, 32'd0);

    // R14: table fill and readback
    for (int i = 0; i < 256; i++) wr(9'h100 | 9'(i), {8'h00, lut_of(i)});
    rd(9'h105, rv);
    check("R14 table readback", rv, {8'h00, lut_of(5)});

    // table-driven unpack and select checks
    for (int n = 0; n < NV; n++) begin
      wr(9'h000, {24'd0, VECS[n].ctrl});
      load(W);
      check("R3 word taken", {31'd0, word_req}, 32'd0);
      for (int p = 0; p <= int'(VECS[n].slot); p++) emit(v, d);
      check("R4 valid one clock later", {31'd0, v}, 32'd1);
      check($sformatf("R1 vector %0d", n), {8'h00, d}, {8'h00, VECS[n].exp});
      drain();
      check("R3 request after last", {31'd0, word_req}, 32'd1);
    end

    // R9 R10 R11: invert and blank applied at frame start only
    wr(9'h000, 32'h1B);
    load(W);
    emit(v, d);
    check("R11 invert waits for frame start", {8'h00, d}, 32'h0000C3);
    fstart(r);
    emit(v, d);
    check("R9 invert all bits", {8'h00, d}, 32'hFFFF5A);
    wr(9'h000, 32'h3B);
    fstart(r);
    emit(v, d);
    check("R10 blank with invert", {8'h00, d}, 32'hFFFFFF);
    wr(9'h000, 32'h2B);
    fstart(r);
    emit(v, d);
    check("R10 blank without invert", {8'h00, d}, 32'h000000);
    check("R3 word used up", {31'd0, word_req}, 32'd1);

    // R13: repeat off never restarts
    wr(9'h000, 32'h08);
    for (int f = 0; f < 6; f++) begin
      fstart(r);
      check("R13 no restart when off", {31'd0, r}, 32'd0);
    end

    // R12: restart on the frame that finds the count at the wrap value
    wr(9'h000, 32'h48);
    for (int f = 0; f < WRAP; f++) begin
      fstart(r);
      check("R12 no early restart", {31'd0, r}, 32'd0);
    end
    fstart(r);
    check("R12 restart pulse", {31'd0, r}, 32'd1);
    @(negedge clk);
    check("R12 pulse one cycle", {31'd0, frame_restart}, 32'd0);

    // R13: disabling clears the count
    fstart(r);
    fstart(r);
    wr(9'h000, 32'h08);
    wr(9'h000, 32'h48);
    for (int f = 0; f < WRAP; f++) begin
      fstart(r);
      check("R13 count restarted from zero", {31'd0, r}, 32'd0);
    end
    fstart(r);
    check("R13 restart after full count", {31'd0, r}, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule